// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a physical address by comparing it against a small set of block-translation entries. Each entry is a pair of 32-bit words, an index word and a real-page word. Two independent sets are kept: instruction fetches search one set, while reads and writes search the other. Each entry carries a block-length mask that widens the address window it covers. The address bits under that mask pass straight through into the physical address.

A request strobe starts a lookup. All entries of the selected set are evaluated in parallel. The lowest-numbered entry that both matches and is valid at the current privilege level decides the outcome. If no entry does, the result is a miss. One cycle after the strobe, the block presents exactly one of three flags: hit, violation or miss. With them it gives the physical address and the read/write/execute permissions that were granted.

A mode input switches to an alternate legacy register layout. In that layout the length mask and the valid bit sit in the real-page word, and permissions come from a key-and-protection check. Entries are loaded through a single-word register write port.

Top module: `bat_xlate`

## Requirements
- R1: After reset, every entry of both sets is invalid and no response flag is raised. A lookup issued before any write returns a miss, with physical address 0 and permissions 3'b000.
- R2: A lookup strobed in one cycle gives its response in the next cycle. `rsp_valid` is high for exactly that one cycle. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_viol`, `rsp_miss` is set, and all three are low otherwise.
- R3: In the standard layout, the index word holds bits [31:28] (high index), [27:17] (low index), [12:2] (length mask L), [1] (supervisor-valid) and [0] (user-valid). An entry matches when ea[31:28] equals the high index and (ea[27:17] & ~L) equals the low index.
- R4: In the standard layout, an entry is valid only through bit [1] when `supervisor`=1 and only through bit [0] when `supervisor`=0.
- R5: In the standard layout, the real-page word holds bits [31:28] (high real page), [27:17] (low real page) and [1:0] (protection code). Code 0 grants nothing. Code 2 grants read, write and execute. Codes 1 and 3 grant read and execute. `rsp_perm` is ordered {read, write, execute}.
- R6: On a hit or a violation, the physical address is {high real page, (ea[27:17] & L) | low real page, ea[16:0]}.
- R7: An entry that matches but is invalid is skipped. The first valid matching entry, by lowest index, decides the result, even when its permission check fails.
- R8: `req_type` is encoded 0 = read, 1 = write, 2 = execute, with 3 treated as read. A request whose needed permission is missing from the deciding entry raises `rsp_viol` and keeps that entry's address and permissions. A miss reports address 0 and permissions 0.
- R9: Execute requests search only the instruction set. Read and write requests search only the data set.
- R10: With `legacy_mode`=1, the length mask is {5'b0, real-page word [5:0]} and validity is real-page word bit [6]. The index word bits [3] and [2] are the supervisor and user key bits, and bits [1:0] are the protection code. The key is bit [3] in supervisor state and bit [2] otherwise. With key 0, codes 0 to 2 give read+write and code 3 gives read. With key 1, code 0 gives nothing, code 2 gives read+write, and codes 1 and 3 give read. Execute is always granted.
- R11: When `wr_en`=1, `wr_data` is stored into entry `wr_idx` of the instruction set when `wr_side`=1 or the data set when `wr_side`=0, into the index word when `wr_upper`=1 and the real-page word otherwise. The new value applies to lookups strobed in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_side | input | 1 | 1 = instruction set, 0 = data set |
| wr_upper | input | 1 | 1 = index word, 0 = real-page word |
| wr_idx | input | 2 | Entry number to write |
| wr_data | input | 32 | Word to store |
| legacy_mode | input | 1 | Selects the legacy register layout |
| supervisor | input | 1 | 1 = supervisor state, 0 = user state |
| req_valid | input | 1 | Lookup strobe |
| req_type | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation granted |
| rsp_viol | output | 1 | Valid match, permission refused |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted permissions {R,W,X} |

## Verification
A zero-length block is probed with one address. A nonzero mask is probed with one address whose masked bits differ from the index, which must still hit and carry those bits into the physical address, and with one address that differs in an unmasked bit, which must miss. This separates correct masking from plain comparison. Privilege is tested by issuing the same address in both states against a supervisor-only entry. Priority is tested with several entries sharing one index: an invalid first entry must be skipped, and a refusing first valid entry must win over a permissive later one. Execute versus data addresses that exist in only one set show which set is searched, and the legacy tests repeat key and length checks with the fields moved between the words.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int ADDR_W = 32;
    localparam int PERM_W = 3;

    // permission vector bit positions
    localparam int PERM_R = 2;
    localparam int PERM_W_BIT = 1;
    localparam int PERM_X = 0;

    // field positions that the matcher decodes
    localparam int HI_MSB  = 31;
    localparam int HI_LSB  = 28;
    localparam int LO_MSB  = 27;
    localparam int LO_LSB  = 17;
    localparam int LEN_W   = LO_MSB - LO_LSB + 1;
    localparam int LEN_MSB = 12;
    localparam int LEN_LSB = 2;
    localparam int SUP_V_BIT = 1;
    localparam int USR_V_BIT = 0;

    localparam int LG_LEN_W   = 6;
    localparam int LG_V_BIT   = 6;
    localparam int LG_KS_BIT  = 3;
    localparam int LG_KU_BIT  = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              viol;
        logic              miss;
        logic [ADDR_W-1:0] paddr;
        logic [PERM_W-1:0] perm;
    } rsp_t;

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_side,
    input  logic                                wr_upper,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [ADDR_W-1:0]                   wr_data,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  i_upper,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  i_lower,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  d_upper,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  d_lower
);

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] iu;
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] il;
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] du;
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] dl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case ({wr_side, wr_upper})
                2'b11:   regs_d.iu[wr_idx] = wr_data;
                2'b10:   regs_d.il[wr_idx] = wr_data;
                2'b01:   regs_d.du[wr_idx] = wr_data;
                default: regs_d.dl[wr_idx] = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign i_upper = regs_q.iu;
    assign i_lower = regs_q.il;
    assign d_upper = regs_q.du;
    assign d_lower = regs_q.dl;

endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
    import bat_pkg::*;
(
    input  logic [ADDR_W-1:0] upper,
    input  logic [ADDR_W-1:0] lower,
    input  logic [ADDR_W-1:0] ea,
    input  logic              legacy,
    input  logic              supervisor,
    output logic              match,
    output logic              valid,
    output logic [PERM_W-1:0] perm,
    output logic [ADDR_W-1:0] paddr
);

    logic [LEN_W-1:0] len_mask;
    logic             key;
    logic [1:0]       pp_std;
    logic [1:0]       pp_lg;
    logic             lg_r, lg_w;
    logic             unused_bits;

    assign unused_bits = ^{upper[16:13], lower[16:7]};

    always_comb begin
        if (legacy) begin
            len_mask = {{(LEN_W-LG_LEN_W){1'b0}}, lower[LG_LEN_W-1:0]};
        end else begin
            len_mask = upper[LEN_MSB:LEN_LSB];
        end

        match = (ea[HI_MSB:HI_LSB] == upper[HI_MSB:HI_LSB]) &&
                ((ea[LO_MSB:LO_LSB] & ~len_mask) == upper[LO_MSB:LO_LSB]);

        pp_std = lower[1:0];
        pp_lg  = upper[1:0];
        key    = supervisor ? upper[LG_KS_BIT] : upper[LG_KU_BIT];

        lg_r = 1'b0;
        lg_w = 1'b0;
        if (!key) begin
            lg_r = 1'b1;
            lg_w = (pp_lg != 2'd3);
        end else begin
            lg_r = (pp_lg != 2'd0);
            lg_w = (pp_lg == 2'd2);
        end

        if (legacy) begin
            valid = lower[LG_V_BIT];
            perm  = {lg_r, lg_w, 1'b1};
        end else begin
            valid = supervisor ? upper[SUP_V_BIT] : upper[USR_V_BIT];
            case (pp_std)
                2'd0:    perm = 3'b000;
                2'd2:    perm = 3'b111;
                default: perm = 3'b101;
            endcase
        end

        paddr = {lower[HI_MSB:HI_LSB],
                 (ea[LO_MSB:LO_LSB] & len_mask) | lower[LO_MSB:LO_LSB],
                 ea[LO_LSB-1:0]};
    end

endmodule

// File: rtl/bat_select.sv
module bat_select
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic [NUM_ENTRIES-1:0]              match,
    input  logic [NUM_ENTRIES-1:0]              valid,
    input  logic [NUM_ENTRIES-1:0][PERM_W-1:0]  perm,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  paddr,
    input  acc_t                                acc,
    output logic                                found,
    output logic                                granted,
    output logic [PERM_W-1:0]                   sel_perm,
    output logic [ADDR_W-1:0]                   sel_paddr
);

    always_comb begin
        found     = 1'b0;
        sel_perm  = '0;
        sel_paddr = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!found && match[i] && valid[i]) begin
                found     = 1'b1;
                sel_perm  = perm[i];
                sel_paddr = paddr[i];
            end
        end

        case (acc)
            ACC_EXEC:  granted = sel_perm[PERM_X];
            ACC_WRITE: granted = sel_perm[PERM_W_BIT];
            default:   granted = sel_perm[PERM_R];
        endcase
        granted = granted && found;
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_side,
    input  logic               wr_upper,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic               legacy_mode,
    input  logic               supervisor,
    input  logic               req_valid,
    input  logic [1:0]         req_type,
    input  logic [ADDR_W-1:0]  req_ea,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_viol,
    output logic               rsp_miss,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [PERM_W-1:0]  rsp_perm
);

    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] i_upper, i_lower, d_upper, d_lower;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] s_upper, s_lower;
    logic [NUM_ENTRIES-1:0]             e_match, e_valid;
    logic [NUM_ENTRIES-1:0][PERM_W-1:0] e_perm;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] e_paddr;
    acc_t                               acc;
    logic                               found, granted;
    logic [PERM_W-1:0]                  sel_perm;
    logic [ADDR_W-1:0]                  sel_paddr;
    rsp_t                               rsp_d, rsp_q;

    bat_regfile #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_side  (wr_side),
        .wr_upper (wr_upper),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .i_upper  (i_upper),
        .i_lower  (i_lower),
        .d_upper  (d_upper),
        .d_lower  (d_lower)
    );

    assign acc     = acc_t'(req_type);
    assign s_upper = (acc == ACC_EXEC) ? i_upper : d_upper;
    assign s_lower = (acc == ACC_EXEC) ? i_lower : d_lower;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        bat_entry_eval u_eval (
            .upper      (s_upper[g]),
            .lower      (s_lower[g]),
            .ea         (req_ea),
            .legacy     (legacy_mode),
            .supervisor (supervisor),
            .match      (e_match[g]),
            .valid      (e_valid[g]),
            .perm       (e_perm[g]),
            .paddr      (e_paddr[g])
        );
    end

    bat_select #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_sel (
        .match     (e_match),
        .valid     (e_valid),
        .perm      (e_perm),
        .paddr     (e_paddr),
        .acc       (acc),
        .found     (found),
        .granted   (granted),
        .sel_perm  (sel_perm),
        .sel_paddr (sel_paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (found) begin
                rsp_d.hit   = granted;
                rsp_d.viol  = !granted;
                rsp_d.paddr = sel_paddr;
                rsp_d.perm  = sel_perm;
            end else begin
                rsp_d.miss  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_viol  = rsp_q.viol;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_perm  = rsp_q.perm;

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_type,
    input logic [16:0] req_ea_lo,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_viol,
    input logic        rsp_miss,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_perm
);

    // R2: response follows the strobe by one cycle
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: one flag per response, none without a response
    a_r2_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_viol, rsp_miss}) == 1));

    a_r2_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_hit, rsp_viol, rsp_miss} == 3'b000));

    // R8: a miss carries no address and no permissions
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == 32'd0 && rsp_perm == 3'b000));

    // R8: a granted execute carries the execute permission
    a_r8_exec_hit_has_x: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 2'd2) |=> (!rsp_hit || rsp_perm[0]));

    // R8: a granted write carries the write permission
    a_r8_write_hit_has_w: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 2'd1) |=> (!rsp_hit || rsp_perm[1]));

    // R6: the low address bits pass through untouched
    a_r6_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!(rsp_hit || rsp_viol) || rsp_paddr[16:0] == $past(req_ea_lo)));

endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_type  (req_type),
    .req_ea_lo (req_ea[16:0]),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_viol  (rsp_viol),
    .rsp_miss  (rsp_miss),
    .rsp_paddr (rsp_paddr),
    .rsp_perm  (rsp_perm)
);

// File: tb/bat_xlate_bench.sv
module bat_xlate_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_side = 1'b0;
    logic        wr_upper = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        legacy_mode = 1'b0;
    logic        supervisor = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_type = '0;
    logic [31:0] req_ea = '0;
    logic        rsp_valid, rsp_hit, rsp_viol, rsp_miss;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bat_xlate u_bat_xlate (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_side (wr_side), .wr_upper (wr_upper),
        .wr_idx (wr_idx), .wr_data (wr_data),
        .legacy_mode (legacy_mode), .supervisor (supervisor),
        .req_valid (req_valid), .req_type (req_type), .req_ea (req_ea),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_viol (rsp_viol),
        .rsp_miss (rsp_miss), .rsp_paddr (rsp_paddr), .rsp_perm (rsp_perm)
    );

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2, RS = 2'd3;
    // expected flag codes {hit,viol,miss}
    localparam logic [2:0] HIT = 3'b100, VIOL = 3'b010, MISS = 3'b001;

    function automatic logic [31:0] std_upper(logic [3:0] hi, logic [10:0] lo,
                                              logic [10:0] len, logic sv, logic uv);
        return {hi, lo, 4'b0, len, sv, uv};
    endfunction

    function automatic logic [31:0] std_lower(logic [3:0] hi, logic [10:0] lo, logic [1:0] pp);
        return {hi, lo, 15'b0, pp};
    endfunction

    function automatic logic [31:0] lg_upper(logic [3:0] hi, logic [10:0] lo,
                                             logic ks, logic ku, logic [1:0] pp);
        return {hi, lo, 13'b0, ks, ku, pp};
    endfunction

    function automatic logic [31:0] lg_lower(logic [3:0] hi, logic [10:0] lo,
                                             logic v, logic [5:0] len);
        return {hi, lo, 10'b0, v, len};
    endfunction

    task automatic write_reg(input logic side, input logic [1:0] idx,
                             input logic upper, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_idx = idx; wr_upper = upper; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic cond, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [1:0] typ, input logic [31:0] ea,
                          input logic [2:0] exp_flags, input logic [31:0] exp_pa,
                          input logic [2:0] exp_perm);
        logic [2:0] flags;
        @(negedge clk);
        req_valid = 1'b1; req_type = typ; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
        flags = {rsp_hit, rsp_viol, rsp_miss};
        check(req, rsp_valid && flags == exp_flags && rsp_paddr == exp_pa && rsp_perm == exp_perm,
              "valid/flags/paddr/perm",
              {27'b0, rsp_valid, flags, rsp_paddr, 2'b0},
              {27'b0, 1'b1, exp_flags, exp_pa, 2'b0});
        if (rsp_perm != exp_perm)
            $display("  perm actual %0b expected %0b", rsp_perm, exp_perm);
    endtask

    task automatic t_reset;
        check("R1", !rsp_valid && !rsp_hit && !rsp_viol && !rsp_miss, "idle after reset",
              {60'b0, rsp_valid, rsp_hit, rsp_viol, rsp_miss}, 64'd0);
        supervisor = 1'b1;
        lookup("R1", RD, 32'h1234_5678, MISS, 32'd0, 3'b000);
        lookup("R1", EX, 32'h0000_0000, MISS, 32'd0, 3'b000);
    endtask

    task automatic t_timing;
        lookup("R2", RD, 32'h0, MISS, 32'd0, 3'b000);
        @(negedge clk);
        check("R2", !rsp_valid && !rsp_miss, "response lasts one cycle",
              {62'b0, rsp_valid, rsp_miss}, 64'd0);
    endtask

    task automatic t_basic_and_mask;
        write_reg(1'b0, 2'd0, 1'b1, std_upper(4'h1, 11'h005, 11'h000, 1'b1, 1'b1));
        write_reg(1'b0, 2'd0, 1'b0, std_lower(4'h8, 11'h100, 2'd2));
        // R11 R6 zero-length block, offset passes through
        lookup("R6", RD, 32'h100A_1ABC, HIT, 32'h8200_1ABC, 3'b111);
        lookup("R11", WR, 32'h100A_1ABC, HIT, 32'h8200_1ABC, 3'b111);
        // unmasked low index bit differs
        lookup("R3", RD, 32'h100C_1ABC, MISS, 32'd0, 3'b000);

        write_reg(1'b0, 2'd1, 1'b1, std_upper(4'h2, 11'h040, 11'h00F, 1'b1, 1'b1));
        write_reg(1'b0, 2'd1, 1'b0, std_lower(4'h3, 11'h200, 2'd1));
        // masked bits differ from index, still match, merged into paddr
        lookup("R3", RD, 32'h2096_5678, HIT, 32'h3416_5678, 3'b101);
        // bit outside the mask differs
        lookup("R3", RD, 32'h20A0_0000, MISS, 32'd0, 3'b000);
        // R5 code 1 forbids writes, R8 violation keeps address
        lookup("R8", WR, 32'h2096_5678, VIOL, 32'h3416_5678, 3'b101);
        // R8 code 3 treated as read
        lookup("R8", RS, 32'h2096_5678, HIT, 32'h3416_5678, 3'b101);
    endtask

    task automatic t_privilege;
        write_reg(1'b0, 2'd2, 1'b1, std_upper(4'h4, 11'h000, 11'h000, 1'b1, 1'b0));
        write_reg(1'b0, 2'd2, 1'b0, std_lower(4'h5, 11'h000, 2'd2));
        supervisor = 1'b1;
        lookup("R4", RD, 32'h4000_0010, HIT, 32'h5000_0010, 3'b111);
        supervisor = 1'b0;
        lookup("R4", RD, 32'h4000_0010, MISS, 32'd0, 3'b000);
        supervisor = 1'b1;
    endtask

    task automatic t_protection;
        write_reg(1'b0, 2'd3, 1'b1, std_upper(4'h6, 11'h000, 11'h000, 1'b1, 1'b1));
        write_reg(1'b0, 2'd3, 1'b0, std_lower(4'h7, 11'h000, 2'd0));
        lookup("R5", RD, 32'h6000_0000, VIOL, 32'h7000_0000, 3'b000);
    endtask

    task automatic t_priority;
        write_reg(1'b1, 2'd0, 1'b1, std_upper(4'h9, 11'h000, 11'h000, 1'b0, 1'b0));
        write_reg(1'b1, 2'd0, 1'b0, std_lower(4'hA, 11'h000, 2'd2));
        write_reg(1'b1, 2'd1, 1'b1, std_upper(4'h9, 11'h000, 11'h000, 1'b1, 1'b1));
        write_reg(1'b1, 2'd1, 1'b0, std_lower(4'hB, 11'h000, 2'd1));
        write_reg(1'b1, 2'd2, 1'b1, std_upper(4'h9, 11'h000, 11'h000, 1'b1, 1'b1));
        write_reg(1'b1, 2'd2, 1'b0, std_lower(4'hC, 11'h000, 2'd2));
        // invalid entry 0 skipped, entry 1 wins over entry 2
        lookup("R7", EX, 32'h9000_0044, HIT, 32'hB000_0044, 3'b101);
        // R9 data side has no such entry, instruction side lacks data entries
        lookup("R9", RD, 32'h9000_0044, MISS, 32'd0, 3'b000);
        lookup("R9", EX, 32'h100A_1ABC, MISS, 32'd0, 3'b000);
        // first valid match refuses, later permissive entry ignored
        write_reg(1'b1, 2'd0, 1'b1, std_upper(4'hA, 11'h000, 11'h000, 1'b1, 1'b1));
        write_reg(1'b1, 2'd0, 1'b0, std_lower(4'hD, 11'h000, 2'd0));
        write_reg(1'b1, 2'd1, 1'b1, std_upper(4'hA, 11'h000, 11'h000, 1'b1, 1'b1));
        write_reg(1'b1, 2'd1, 1'b0, std_lower(4'hE, 11'h000, 2'd2));
        lookup("R7", EX, 32'hA000_0000, VIOL, 32'hD000_0000, 3'b000);
    endtask

    task automatic t_legacy;
        legacy_mode = 1'b1;
        write_reg(1'b0, 2'd0, 1'b1, lg_upper(4'h1, 11'h010, 1'b0, 1'b1, 2'd1));
        write_reg(1'b0, 2'd0, 1'b0, lg_lower(4'h4, 11'h000, 1'b1, 6'h0F));
        supervisor = 1'b1;
        lookup("R10", RD, 32'h1036_0ABC, HIT, 32'h4016_0ABC, 3'b111);
        lookup("R10", WR, 32'h1036_0ABC, HIT, 32'h4016_0ABC, 3'b111);
        supervisor = 1'b0;
        lookup("R10", RD, 32'h1036_0ABC, HIT, 32'h4016_0ABC, 3'b101);
        lookup("R10", WR, 32'h1036_0ABC, VIOL, 32'h4016_0ABC, 3'b101);
        supervisor = 1'b1;
        // unmasked low index bit outside the 6-bit length
        lookup("R10", RD, 32'h1056_0ABC, MISS, 32'd0, 3'b000);
        write_reg(1'b0, 2'd0, 1'b0, lg_lower(4'h4, 11'h000, 1'b0, 6'h0F));
        lookup("R10", RD, 32'h1036_0ABC, MISS, 32'd0, 3'b000);
        legacy_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_basic_and_mask();
        t_privilege();
        t_protection();
        t_priority();
        t_legacy();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule